// File: doc/BRIEF.md
# Multi-Mode Interval Timer

This block is a counter timer for a control subsystem. A tick enable is taken from one of four clock-source enable lines, all of them already synchronous to the system clock. It passes through a power-of-two prescaler and then drives a 16-bit counter. The counter can hold, count up to a programmable period, count freely across the full range, or count up to the period and back down to zero.

Software programs the block through a plain register write port and reads it back through a combinational read port. The block raises a sticky overflow flag each time the count returns to zero. An enable bit gates that flag onto the interrupt output. A one-cycle period-match strobe marks each count that lands on the period value, for use by neighbouring compare logic. A self-clearing clear bit in the control register restarts the count, the prescaler and the counting direction.

The write port has no back-pressure. A write is taken on every clock edge where the write enable is high, and the read data is a pure function of the read address and the current state.

Top module: `mode_timer`

## Requirements
- R1: After reset the count, the period, all control fields, the overflow flag, the interrupt output and the match strobe are all zero.
- R2: The mode field is control bits [1:0]: 00 holds the count unchanged without clearing it, 01 counts up to the period, 10 counts across the full range, and 11 counts up to the period and then down to zero.
- R3: In mode 01, each tick adds one to the count. A tick when the count is at or above the period returns it to 0 and sets the overflow flag.
- R4: In mode 10, the count wraps from 0xFFFF to 0 and the overflow flag sets on that wrap.
- R5: In mode 11, the count turns from the period value to period-1 and descends. On the step from 1 to 0 it sets the overflow flag and resumes counting up.
- R6: The divider field, control bits [3:2], gives one counter tick per 1, 2, 4 or 8 enables of the selected source for codes 00, 01, 10 and 11.
- R7: The source field, control bits [5:4], selects which bit of the four-bit source-enable input advances the prescaler. The other bits have no effect.
- R8: Writing 1 to control bit 6 zeroes the count, the prescaler and the direction, and overrides a tick on the same edge. The bit always reads back as 0.
- R9: The overflow flag, control bit 8, stays set until a control write carries 0 in that bit. Writing 1 leaves it unchanged. The interrupt output is the flag ANDed with the enable in control bit 7.
- R10: The match output is high for one system cycle, in the cycle after a tick moves the count onto the period value.
- R11: Address 0 is control, address 1 is the count and address 2 is the period, each writable and readable. Address 3 reads 0. A count write overrides a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_src_i | input | 4 | Source enables, one per selectable source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |
| period_match_o | output | 1 | Period-match strobe |

## Verification
The assertions check four behaviours on every cycle. Mode 00 holds the count. The up-mode rollover and the full-range wrap both land on zero. A clear leaves a zero count counting upward, and every match strobe agrees with the count and with the period that was in force. The flag's stickiness is also checked against the write that would clear it. Other behaviours can only be shown by the bench's scenarios, because they span many ticks and depend on the programmed sequence. These are the up/down turnaround and its overflow point, the prescale ratios, the effect of the source selection, the prescaler reset by a clear, and the register readback.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_PERIOD = 2'd2;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int N_SRC = 4,
  parameter int DIV_W = 2,
  localparam int SEL_W = $clog2(N_SRC),
  localparam int PRE_W = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             sel_en;

  assign sel_en = src_i[sel_i];
  assign mask   = ~({PRE_W{1'b1}} << div_i);
  assign tick_o = sel_en && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (sel_en) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter
  import mode_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_e        mode_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         match_o
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         dn_q, dn_nxt;
  logic         match_q;
  logic         adv;

  assign adv = tick_i && (mode_i != MODE_STOP) && !clr_i && !ld_i;

  always_comb begin
    cnt_nxt = cnt_q;
    dn_nxt  = dn_q;
    wrap_o  = 1'b0;
    if (clr_i) begin
      cnt_nxt = '0;
      dn_nxt  = 1'b0;
    end else if (ld_i) begin
      cnt_nxt = ld_val_i;
    end else if (adv) begin
      unique case (mode_i)
        MODE_UP: begin
          dn_nxt = 1'b0;
          if (cnt_q >= period_i) begin
            cnt_nxt = '0;
            wrap_o  = 1'b1;
          end else begin
            cnt_nxt = cnt_q + 1'b1;
          end
        end
        MODE_CONT: begin
          dn_nxt  = 1'b0;
          cnt_nxt = cnt_q + 1'b1;
          wrap_o  = &cnt_q;
        end
        MODE_UPDN: begin
          if (!dn_q) begin
            if (cnt_q >= period_i) begin
              if (cnt_q != '0) begin
                cnt_nxt = cnt_q - 1'b1;
                dn_nxt  = 1'b1;
              end
            end else begin
              cnt_nxt = cnt_q + 1'b1;
            end
          end else if (cnt_q <= W'(1)) begin
            cnt_nxt = '0;
            dn_nxt  = 1'b0;
            wrap_o  = (cnt_q == W'(1));
          end else begin
            cnt_nxt = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dn_q    <= 1'b0;
      match_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      dn_q    <= dn_nxt;
      match_q <= adv && (cnt_nxt == period_i);
    end
  end

  assign cnt_o   = cnt_q;
  assign match_o = match_q;

  assert_stop_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && !clr_i && !ld_i) |=> $stable(cnt_q));
  assert_up_rollover_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && tick_i && !clr_i && !ld_i && cnt_q >= period_i) |=> (cnt_q == '0));
  assert_cont_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CONT && tick_i && !clr_i && !ld_i && (&cnt_q)) |=> (cnt_q == '0));
  assert_clear_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dn_q));
  assert_match_value_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> (cnt_q == $past(period_i)));
endmodule

// File: rtl/mt_regs.sv
module mt_regs
  import mode_timer_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 2,
  parameter int SEL_W = 2,
  localparam int DIV_LO = 2,
  localparam int SEL_LO = DIV_LO + DIV_W,
  localparam int CLR_B  = SEL_LO + SEL_W,
  localparam int IEN_B  = CLR_B + 1,
  localparam int FLG_B  = CLR_B + 2,
  localparam int PAD_W  = W - FLG_B - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [W-1:0]     rd_data_o,
  input  logic [W-1:0]     cnt_i,
  input  logic             wrap_i,
  output mode_e            mode_o,
  output logic [DIV_W-1:0] div_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clr_o,
  output logic             ld_o,
  output logic [W-1:0]     period_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic ctrl_wr;
  logic ien_q;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_o   = ctrl_wr && wr_data_i[CLR_B];
  assign ld_o    = wr_en_i && (wr_addr_i == ADDR_COUNT);
  assign irq_o   = flag_o && ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_STOP;
      div_o    <= '0;
      sel_o    <= '0;
      ien_q    <= 1'b0;
      flag_o   <= 1'b0;
      period_o <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_o <= mode_e'(wr_data_i[1:0]);
        div_o  <= wr_data_i[DIV_LO +: DIV_W];
        sel_o  <= wr_data_i[SEL_LO +: SEL_W];
        ien_q  <= wr_data_i[IEN_B];
      end
      if (wrap_i)       flag_o <= 1'b1;
      else if (ctrl_wr) flag_o <= flag_o & wr_data_i[FLG_B];
      if (wr_en_i && wr_addr_i == ADDR_PERIOD) period_o <= wr_data_i;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL:   rd_data_o = {{PAD_W{1'b0}}, flag_o, ien_q, 1'b0, sel_o, div_o, mode_o};
      ADDR_COUNT:  rd_data_o = cnt_i;
      ADDR_PERIOD: rd_data_o = period_o;
      default:     rd_data_o = '0;
    endcase
  end

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(ctrl_wr && !wr_data_i[FLG_B])) |=> flag_o);
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mode_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_SRC = 4,
  parameter int DIV_W = 2,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] clk_src_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             irq_o,
  output logic             period_match_o
);
  mode_e            mode;
  logic [DIV_W-1:0] div;
  logic [SEL_W-1:0] sel;
  logic             clr, ld, tick, wrap;
  logic [CNT_W-1:0] period;

  mt_regs #(.W(CNT_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .cnt_i(count_o), .wrap_i(wrap),
    .mode_o(mode), .div_o(div), .sel_o(sel), .clr_o(clr), .ld_o(ld),
    .period_o(period), .flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  mt_prescaler #(.N_SRC(N_SRC), .DIV_W(DIV_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(clk_src_i), .sel_i(sel),
    .div_i(div), .clr_i(clr), .tick_o(tick)
  );

  mt_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .tick_i(tick),
    .clr_i(clr), .ld_i(ld), .ld_val_i(wr_data_i), .period_i(period),
    .cnt_o(count_o), .wrap_o(wrap), .match_o(period_match_o)
  );
endmodule

// File: tb/mode_timer_tb.sv
`timescale 1ns/1ps
module mode_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src = 4'b0001;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data, count;
  logic        flag, irq, match;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  mode_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_src_i(src),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .count_o(count),
    .ovf_flag_o(flag), .irq_o(irq), .period_match_o(match)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 flag", flag, 0);
    check("R1 irq", irq, 0);
    check("R1 match", match, 0);
    rd_addr = 2'd0; #0.1 check("R1 ctrl", rd_data, 0);
    rd_addr = 2'd2; #0.1 check("R1 period", rd_data, 0);
  endtask

  task automatic t_up_and_stop();
    wr(2'd2, 16'd3);
    wr(2'd0, 16'h0041);
    check("R8 clear count", count, 0);
    for (int i = 1; i <= 6; i++) begin
      step(1);
      check("R3 up count", count, i % 4);
      check("R10 match up", match, (i % 4) == 3);
      if (i == 3) check("R3 flag before rollover", flag, 0);
      if (i == 4) check("R3 flag on rollover", flag, 1);
    end
    check("R9 irq gated off", irq, 0);
    rd_addr = 2'd0; #0.1 check("R8 clear reads zero", rd_data, 16'h0101);
    wr(2'd0, 16'h0100);
    check("R2 last tick before stop", count, 3);
    step(3);
    check("R2 stop holds count", count, 3);
    check("R9 write one keeps flag", flag, 1);
    wr(2'd0, 16'h0000);
    check("R9 write zero clears flag", flag, 0);
  endtask

  task automatic t_cont();
    wr(2'd1, 16'hFFFD);
    check("R11 count load", count, 16'hFFFD);
    wr(2'd0, 16'h0082);
    check("R4 start value", count, 16'hFFFD);
    step(2);
    check("R4 at max", count, 16'hFFFF);
    check("R4 no flag yet", flag, 0);
    check("R9 no irq yet", irq, 0);
    step(1);
    check("R4 wrap to zero", count, 0);
    check("R4 flag on wrap", flag, 1);
    check("R9 irq enabled", irq, 1);
    wr(2'd0, 16'h0000);
    check("R9 irq cleared", irq, 0);
    check("R2 count after stop", count, 1);
  endtask

  task automatic t_updn();
    logic [15:0] seq [8] = '{16'd1, 16'd2, 16'd1, 16'd0, 16'd1, 16'd2, 16'd1, 16'd0};
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0043);
    for (int i = 0; i < 8; i++) begin
      step(1);
      check("R5 updown count", count, seq[i]);
      check("R10 match updown", match, seq[i] == 16'd2);
      if (i == 2) check("R5 no flag at turnaround", flag, 0);
      if (i == 3) check("R5 flag at zero", flag, 1);
    end
  endtask

  task automatic t_clear_dir();
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0043);
    step(6);
    check("R5 descending", count, 4);
    wr(2'd0, 16'h0043);
    check("R8 clear mid count", count, 0);
    step(2);
    check("R8 direction reset up", count, 2);
    rd_addr = 2'd0; #0.1 check("R8 ctrl readback", rd_data, 16'h0003);
  endtask

  task automatic t_prescale();
    wr(2'd2, 16'd100);
    wr(2'd0, 16'h0049);
    for (int i = 1; i <= 8; i++) begin
      step(1);
      check("R6 divide by 4", count, i / 4);
    end
    step(2);
    wr(2'd0, 16'h0049);
    step(3);
    check("R8 prescaler cleared", count, 0);
    step(1);
    check("R8 first tick after clear", count, 1);
    wr(2'd0, 16'h0045);
    for (int i = 1; i <= 4; i++) begin
      step(1);
      check("R6 divide by 2", count, i / 2);
    end
    wr(2'd0, 16'h004D);
    step(7);
    check("R6 divide by 8 early", count, 0);
    step(1);
    check("R6 divide by 8", count, 1);
  endtask

  task automatic t_select();
    wr(2'd0, 16'h0051);
    step(3);
    check("R7 other source ignored", count, 0);
    src = 4'b0010; step(1);
    check("R7 selected source ticks", count, 1);
    src = 4'b1101; step(2);
    check("R7 unselected sources", count, 1);
    src = 4'b0010; step(2);
    check("R7 two more ticks", count, 3);
    src = 4'b0001;
  endtask

  task automatic t_regs();
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h1234);
    rd_addr = 2'd2; #0.1 check("R11 period readback", rd_data, 16'h1234);
    wr(2'd1, 16'h0042);
    rd_addr = 2'd1; #0.1 check("R11 count readback", rd_data, 16'h0042);
    check("R11 count port", count, 16'h0042);
    rd_addr = 2'd3; #0.1 check("R11 unused address", rd_data, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_up_and_stop();
    t_cont();
    t_updn();
    t_clear_dir();
    t_prescale();
    t_select();
    t_regs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule